// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block models a one-bit-wide serial memory of the kind used to feed configuration data to a programmable device over a single wire. A fixed number of bits sits in an internal array. An address counter walks through that array one bit per rising clock edge. The bit at the current address drives the data output whenever the device is selected and out of reset.

Several instances can share one clock and one data line. Each device's chip-enable-out feeds the chip-enable of the next device. When a device has delivered its last bit, it releases the line and enables its successor. The combined stream therefore flows with no idle cycle between devices.

A single pin acts as counter reset and as output enable, and a parameter sets its polarity. The contents come from a parameter, or are written through a simple bit-write port that only a test environment uses.

Top module: `serial_cfg_store`

## Requirements
- R1: While chip enable is active (`ce_n` = 0) and reset is inactive, each rising edge of `clk` advances the address by one, and `dout` shows the stored bit at the current address.
- R2: While reset is active, each edge clears the address to 0 and clears the exhausted state. `dout_en` stays 0 and `ceo_n` stays 1 throughout.
- R3: With `RST_HIGH` = 1, `rst_oe` = 1 means reset and `rst_oe` = 0 means output enabled. With `RST_HIGH` = 0, the levels are the other way round.
- R4: While `ce_n` = 1, the address does not change, `dout_en` is 0 whatever `rst_oe` is, and `standby` is 1. While `ce_n` = 0, `standby` is 0.
- R5: The clocking edge at address DEPTH-1 sets the exhausted state instead of wrapping. From then on the address holds, `dout_en` is 0, and this lasts until a reset.
- R6: `ceo_n` is 0 exactly when chip enable is active, reset is inactive and the device is exhausted. Once the device is exhausted, `ceo_n` therefore follows `ce_n`.
- R7: In a chain where the next device takes `ceo_n` as its `ce_n`, the shared line carries all bits of the first device, then all bits of the second, with no idle cycle. At most one `dout_en` is high in any cycle.
- R8: Bit i of `INIT` is the content of address i. A clock edge with `wr_en` = 1 stores `wr_data` at address `wr_addr`.
- R9: Whenever `dout_en` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined counter reset / output enable, polarity set by `RST_HIGH` |
| wr_en | input | 1 | Test-only bit write strobe |
| wr_addr | input | AW | Test-only write address |
| wr_data | input | 1 | Test-only write bit |
| dout | output | 1 | Serial data bit, 0 when not driving |
| dout_en | output | 1 | Data driver enable, stands in for the tri-state control |
| ceo_n | output | 1 | Chip enable to the next device, active low |
| standby | output | 1 | High while the device is deselected |

## Verification
The checker tests these properties on every edge:
- the address is zero after a reset edge;
- the address is frozen while the device is deselected;
- the address steps by exactly one while the device is being read;
- once exhausted, the device stays exhausted with a frozen address;
- the data driver and the chip-enable output are never active together;
- the data driver is off during reset and standby.

Only the two-device bench scenarios can show the following:
- that the concatenated stream is seamless and arrives in the right order;
- that a mid-stream reset restarts from the first device;
- that the polarity parameter works;
- that written contents appear at the right address.

// File: rtl/serial_cfg_store.sv
module serial_cfg_store #(
  parameter int DEPTH = 16,
  parameter logic [DEPTH-1:0] INIT = '0,
  parameter bit RST_HIGH = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  output logic          dout,
  output logic          dout_en,
  output logic          ceo_n,
  output logic          standby
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0] mem = INIT;
  logic [AW-1:0]    addr;
  logic             spent;
  logic             rst_act, sel;

  assign rst_act = RST_HIGH ? rst_oe : ~rst_oe;
  assign sel     = ~ce_n & ~rst_act;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst_act) begin
      addr  <= '0;
      spent <= 1'b0;
    end else if (!ce_n && !spent) begin
      if (addr == LAST) spent <= 1'b1;
      else              addr  <= addr + 1'b1;
    end
  end

  assign dout_en = sel & ~spent;
  assign dout    = dout_en & mem[addr];
  assign ceo_n   = ~(sel & spent);
  assign standby = ce_n;
endmodule

// File: rtl/serial_cfg_store_chk.sv
module serial_cfg_store_chk #(
  parameter int AW = 4,
  parameter bit RST_HIGH = 1'b1
) (
  input logic          clk,
  input logic          ce_n,
  input logic          rst_oe,
  input logic [AW-1:0] addr,
  input logic          spent,
  input logic          dout_en,
  input logic          ceo_n,
  input logic          standby
);
  logic rst_act;
  logic prev_rst = 1'b0;
  assign rst_act = RST_HIGH ? rst_oe : ~rst_oe;

  always @(posedge clk) begin
    prev_rst <= rst_act;
    if (prev_rst) AST_RST_ZERO: assert (addr == '0 && !spent) else $error("reset left state"); // R2
    AST_RST_FLOAT: assert (!(rst_act && dout_en)) else $error("driving in reset"); // R2
    AST_STBY_FLOAT: assert (!(ce_n && (dout_en || !standby))) else $error("driving in standby"); // R4
    AST_NO_CONTEND: assert (!(dout_en && !ceo_n)) else $error("data and handoff together"); // R7
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |=> $stable(addr)) else $error("address moved while deselected"); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst_act)
    (!ce_n && !spent) |=> (spent || addr == $past(addr) + 1'b1)) else $error("bad step"); // R1
  AST_STAY_SPENT: assert property (@(posedge clk) disable iff (rst_act)
    spent |=> (spent && $stable(addr))) else $error("left exhausted state"); // R5
endmodule

bind serial_cfg_store serial_cfg_store_chk #(.AW(AW), .RST_HIGH(RST_HIGH)) u_chk (
  .clk(clk), .ce_n(ce_n), .rst_oe(rst_oe), .addr(addr), .spent(spent),
  .dout_en(dout_en), .ceo_n(ceo_n), .standby(standby)
);

// File: tb/serial_cfg_store_bench.sv
`timescale 1ns/1ps
module serial_cfg_store_bench;
  localparam int N0 = 12;
  localparam int N1 = 8;
  localparam logic [N0-1:0] IMG0 = 12'b1011_0010_1110;
  localparam logic [N1-1:0] IMG1 = 8'b0110_1001;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, ce_n0 = 1'b1, rst_lo = 1'b0, ce_lo_n = 1'b1;
  logic wr_en1 = 1'b0, wr_data1 = 1'b0;
  logic [2:0] wr_addr1 = '0;
  logic d0, e0, c0, s0, d1, e1, c1, s1, dl, el, cl, sl;

  serial_cfg_store #(.DEPTH(N0), .INIT(IMG0)) u_serial_cfg_store (
    .clk(clk), .ce_n(ce_n0), .rst_oe(rst), .wr_en(1'b0), .wr_addr(4'd0), .wr_data(1'b0),
    .dout(d0), .dout_en(e0), .ceo_n(c0), .standby(s0));
  serial_cfg_store #(.DEPTH(N1)) u_serial_cfg_store_b (
    .clk(clk), .ce_n(c0), .rst_oe(rst), .wr_en(wr_en1), .wr_addr(wr_addr1), .wr_data(wr_data1),
    .dout(d1), .dout_en(e1), .ceo_n(c1), .standby(s1));
  serial_cfg_store #(.DEPTH(N0), .INIT(IMG0), .RST_HIGH(1'b0)) u_lo (
    .clk(clk), .ce_n(ce_lo_n), .rst_oe(rst_lo), .wr_en(1'b0), .wr_addr(4'd0), .wr_data(1'b0),
    .dout(dl), .dout_en(el), .ceo_n(cl), .standby(sl));

  int total = 0, fails = 0;
  int p[3];
  bit sp[3];
  logic [N1-1:0] img1 = '0;
  bit stream[$];
  bit collect = 1'b0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic mbit(int d);
    return (d == 1) ? img1[p[1]] : IMG0[p[d]];
  endfunction

  function automatic bit rsta(int d);
    return (d == 2) ? !rst_lo : rst;
  endfunction

  function automatic bit cea(int d);
    if (d == 0) return !ce_n0;
    if (d == 2) return !ce_lo_n;
    return !rst && !ce_n0 && sp[0];
  endfunction

  task automatic model_edge();
    bit ce_now[3];
    for (int d = 0; d < 3; d++) ce_now[d] = cea(d);
    for (int d = 0; d < 3; d++) begin
      if (rsta(d)) begin p[d] = 0; sp[d] = 0; end
      else if (ce_now[d] && !sp[d]) begin
        if (p[d] == ((d == 1) ? N1 : N0) - 1) sp[d] = 1;
        else p[d]++;
      end
    end
  endtask

  task automatic compare();
    logic ad[3], ae[3], ac[3], as[3];
    ad = '{d0, d1, dl}; ae = '{e0, e1, el}; ac = '{c0, c1, cl}; as = '{s0, s1, sl};
    for (int d = 0; d < 3; d++) begin
      bit sel = cea(d) && !rsta(d);
      bit en = sel && !sp[d];
      chk("R1 dout_en", ae[d], en);
      chk("R9 dout", ad[d], en ? mbit(d) : 1'b0);
      chk("R6 ceo_n", ac[d], !(sel && sp[d]));
      chk("R4 standby", as[d], !cea(d));
    end
    chk("R7 single driver", e0 & e1, 1'b0);
  endtask

  task automatic tick();
    #1;
    if (collect && !ce_n0 && !rst) begin
      if (e0 ^ e1) stream.push_back(e0 ? d0 : d1);
      else if (stream.size() < N0 + N1) chk("R7 gap", 1'b1, 1'b0);
    end
    @(posedge clk);
    model_edge();
    if (wr_en1) img1[wr_addr1] = wr_data1;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++) begin p[d] = 0; sp[d] = 0; end
    @(negedge clk);
    tick(); tick();
    chk("R2 no drive in reset", e0, 1'b0);
    chk("R2 ceo high in reset", c0, 1'b1);
    chk("R3 low-polarity reset holds off", el, 1'b0);
    // R8: load second device through write port during reset
    for (int i = 0; i < N1; i++) begin
      wr_en1 = 1'b1; wr_addr1 = 3'(i); wr_data1 = IMG1[i];
      tick();
    end
    wr_en1 = 1'b0;
    // R3: active-low instance runs when pin high
    rst_lo = 1'b1; ce_lo_n = 1'b0;
    #1 chk("R3 low-polarity enabled", el, 1'b1);
    chk("R3 first bit", dl, IMG0[0]);
    rst = 1'b0; ce_n0 = 1'b0; collect = 1'b1;
    repeat (5) tick();
    ce_n0 = 1'b1;
    repeat (3) tick();
    chk("R4 paused standby", s0, 1'b1);
    chk("R4 paused no drive", e0, 1'b0);
    ce_n0 = 1'b0;
    repeat (N0 + N1 - 5) tick();
    repeat (3) tick();
    chk("R5 first exhausted", e0, 1'b0);
    chk("R5 second exhausted", e1, 1'b0);
    chk("R6 last ceo low", c1, 1'b0);
    total++;
    if (stream.size() != N0 + N1) begin
      fails++;
      $display("FAIL R7 stream length: got %0d expected %0d", stream.size(), N0 + N1);
    end else begin
      for (int i = 0; i < N0 + N1; i++)
        chk("R7/R8 stream bit", stream[i], (i < N0) ? IMG0[i] : IMG1[i - N0]);
    end
    ce_n0 = 1'b1;
    tick();
    chk("R6 ceo follows ce", c0, 1'b1);
    chk("R6 next deselected", s1, 1'b1);
    ce_n0 = 1'b0;
    tick();
    chk("R6 ceo back low", c0, 1'b0);
    // R2: reset restarts from the first device
    collect = 1'b0;
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    stream.delete(); collect = 1'b1;
    repeat (3) tick();
    collect = 1'b0;
    total++;
    if (stream.size() != 3) begin
      fails++;
      $display("FAIL R2 restart length: got %0d expected 3", stream.size());
    end else
      for (int i = 0; i < 3; i++) chk("R2 restart bit", stream[i], IMG0[i]);
    rst_lo = 1'b0;
    tick();
    chk("R3 low-polarity reset again", el, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule